// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

A clocked, synthesizable model of a 16-bit-wide asynchronous static RAM. It is meant for two uses: as the memory behind a memory-controller testbench, and as an on-chip loopback target. The active-low control pins are chip select, output enable, write strobe and one enable per byte. A fast internal clock samples them, and the block decodes each combination into one of four modes: standby, output disabled, read or write. The data path has no tristate pad. It uses a separate input bus, an output bus and a per-lane drive flag. Undriven lanes read as zero on the output bus, so a bench can check for high impedance without modelling it.

Writes follow the overlap rule of asynchronous parts. A write is open while chip select, the write strobe and at least one byte enable are all low. It closes when any of the three rises. The word committed is the data, address and lane set held in the last sampled cycle before the close. The write strobe may stay low while the byte enables pulse once per word, which gives back-to-back writes. The external address is 20 bits wide. The storage depth is set by a separate parameter, so small instances simulate quickly. Reset does not clear the contents.

Top module: `sram_lane_emu`

## Requirements
- R1: While sampled chip select is high (1), both bits of `lane_oe` are 0, whatever the other controls are.
- R2: With chip select low, write strobe high and output enable high, both bits of `lane_oe` are 0.
- R3: With both byte enables high, no lane is driven and no storage is changed, even while chip select and the write strobe are low.
- R4: A read drives a lane when chip select is low, the write strobe is high and output enable is low. `lane_oe[0]` and `dout[7:0]` follow the lower enable, and `lane_oe[1]` and `dout[15:8]` follow the upper enable. The data shown is the stored word at the sampled address, one clock after the inputs are sampled.
- R5: A write changes only the byte lanes whose enable is low, and output enable has no effect on it.
- R6: A write commits the data, address and lanes sampled in the last clock before the write window closes. Data presented in the same cycle that the window closes is not written.
- R7: With the write strobe held low, successive pulses of the byte enables write successive words, each to the address present during its own pulse.
- R8: While the write strobe is low, `lane_oe` is 0.
- R9: After reset, `lane_oe` is 0 until new controls are sampled.
- R10: Any lane whose `lane_oe` bit is 0 reads as 8'h00 on `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address; only the low MEM_AW bits select storage |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| ub_n | input | 1 | Upper byte enable (bits 15:8), active low |
| lb_n | input | 1 | Lower byte enable (bits 7:0), active low |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, zero on undriven lanes |
| lane_oe | output | 2 | Per-lane drive flag, bit 0 lower, bit 1 upper |

## Verification
The bench sweeps all 32 control combinations against a known stored word. A decode that drove a lane during a write, or ignored one byte enable, would show a wrong `lane_oe` bit or a non-zero byte on an undriven lane. Single-lane writes made with output enable low would expose a mask that spilled into the other byte. One write window changes its data in the cycle the window closes, so a design that captured at the close instead of before it would store the late value. Back-to-back writes under a held-low strobe catch a design that only commits on the rising edge of the write strobe, because that design would lose every word but the last.

// File: rtl/sram_lane_emu.sv
module sram_lane_emu #(
  parameter int ADDR_W = 20,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        lane_oe
);
  localparam int DEPTH = 1 << MEM_AW;

  logic              ce_q, oe_q, we_q, ub_q, lb_q;
  logic [MEM_AW-1:0] a_q, cap_a;
  logic [15:0]       d_q, cap_d, rd;
  logic [1:0]        cap_be;
  logic              win, win_d, commit, drv;
  logic [15:0]       mem [DEPTH];
  logic              unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:MEM_AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ce_q, oe_q, we_q, ub_q, lb_q} <= 5'b11111;
      win_d <= 1'b0;
    end else begin
      {ce_q, oe_q, we_q, ub_q, lb_q} <= {ce_n, oe_n, we_n, ub_n, lb_n};
      win_d <= win;
    end
  end

  always_ff @(posedge clk) begin
    a_q <= addr[MEM_AW-1:0];
    d_q <= din;
  end

  assign win    = ~ce_q & ~we_q & (~ub_q | ~lb_q);
  assign commit = win_d & ~win;

  always_ff @(posedge clk) begin
    if (win) begin
      cap_a  <= a_q;
      cap_d  <= d_q;
      cap_be <= {~ub_q, ~lb_q};
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      if (cap_be[0]) mem[cap_a][7:0]  <= cap_d[7:0];
      if (cap_be[1]) mem[cap_a][15:8] <= cap_d[15:8];
    end
  end

  assign drv     = ~ce_q & we_q & ~oe_q;
  assign lane_oe = {drv & ~ub_q, drv & ~lb_q};
  assign rd      = mem[a_q];
  assign dout    = {lane_oe[1] ? rd[15:8] : 8'h00, lane_oe[0] ? rd[7:0] : 8'h00};

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> lane_oe == 2'b00); // R1
  AST_OUTDIS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ce_n) && $past(we_n) && $past(oe_n)) |-> lane_oe == 2'b00); // R2
  AST_NOBYTE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ub_n) && $past(lb_n)) |-> lane_oe == 2'b00); // R3
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!we_n) |-> lane_oe == 2'b00); // R8
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> dout == 16'h0000); // R10
endmodule

// File: tb/sram_lane_emu_tb.sv
module sram_lane_emu_tb;
  localparam int AW = 4;
  logic clk = 0, rst_n = 0;
  logic [19:0] addr = '0;
  logic ce_n = 1, oe_n = 1, we_n = 1, ub_n = 1, lb_n = 1;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0] lane_oe;
  logic [15:0] model [16];
  int checks = 0, fails = 0;

  sram_lane_emu #(.ADDR_W(20), .MEM_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n), .din(din), .dout(dout), .lane_oe(lane_oe));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    {ce_n, oe_n, we_n, ub_n, lb_n} = 5'b11111;
    cyc(3);
  endtask

  task automatic wr(input int a, input logic [15:0] d, input bit lo, input bit hi, input bit oe);
    addr = 20'(a); din = d; oe_n = oe; ce_n = 0; we_n = 0; lb_n = ~lo; ub_n = ~hi;
    cyc(2);
    ce_n = 1;
    if (lo) model[a][7:0] = d[7:0];
    if (hi) model[a][15:8] = d[15:8];
    idle();
  endtask

  task automatic rd_chk(input int a, input string tag);
    addr = 20'(a); ce_n = 0; we_n = 1; oe_n = 0; lb_n = 0; ub_n = 0;
    cyc(2);
    chk(dout === model[a] && lane_oe == 2'b11, tag, {16'h0, dout}, {16'h0, model[a]});
    idle();
  endtask

  initial begin
    cyc(2);
    chk(lane_oe == 2'b00 && dout == 16'h0, "R9 reset", {30'h0, lane_oe}, 0);
    rst_n = 1;
    cyc(2);
    chk(lane_oe == 2'b00, "R9 after reset idle", {30'h0, lane_oe}, 0);

    for (int a = 0; a < 16; a++) wr(a, 16'(a * 16'h1111) ^ 16'hA5C3, 1, 1, 1);
    for (int a = 0; a < 16; a++) rd_chk(a, "R4 full read");

    // control sweep at address 3, bits {ce,we,oe,ub,lb}
    for (int c = 0; c < 32; c++) begin
      logic [1:0] exl;
      logic [15:0] exd;
      bit dr;
      addr = 20'd3; din = model[3];
      {ce_n, we_n, oe_n, ub_n, lb_n} = 5'(c);
      cyc(2);
      dr = !ce_n && we_n && !oe_n;
      exl = {dr && !ub_n, dr && !lb_n};
      exd = {exl[1] ? model[3][15:8] : 8'h00, exl[0] ? model[3][7:0] : 8'h00};
      chk(lane_oe == exl, "R1 R2 R3 R8 sweep lane_oe", {27'h0, 5'(c)}, {30'h0, exl});
      chk(dout === exd, "R4 R10 sweep dout", {16'h0, dout}, {16'h0, exd});
    end
    idle();
    rd_chk(3, "R5 sweep left word intact");

    wr(5, 16'hBEEF, 1, 0, 0);
    rd_chk(5, "R5 lower-only write with oe low");
    wr(6, 16'h1234, 0, 1, 0);
    rd_chk(6, "R5 upper-only write with oe low");
    wr(7, 16'h0000, 0, 0, 0);
    rd_chk(7, "R3 no byte enable leaves word");

    // R6: data changes in the closing cycle
    addr = 20'd9; ce_n = 0; we_n = 0; oe_n = 1; lb_n = 0; ub_n = 0; din = 16'h1111;
    cyc(1);
    din = 16'h2222;
    cyc(1);
    we_n = 1; din = 16'h3333;
    cyc(1);
    model[9] = 16'h2222;
    idle();
    rd_chk(9, "R6 last in-window data committed");

    // R6: lower enable closes a lower-only window
    addr = 20'd10; ce_n = 0; we_n = 0; lb_n = 0; ub_n = 1; din = 16'h00AB;
    cyc(2);
    lb_n = 1; din = 16'h00CD;
    cyc(1);
    model[10][7:0] = 8'hAB;
    idle();
    rd_chk(10, "R6 byte enable closes window");

    // R7: strobe held low, byte enables pulse
    ce_n = 0; we_n = 0; oe_n = 0;
    for (int i = 0; i < 4; i++) begin
      addr = 20'(12 + i); din = 16'hC0DE + 16'(i * 16'h0101);
      lb_n = 0; ub_n = 0;
      cyc(2);
      chk(lane_oe == 2'b00, "R8 no drive during write", {30'h0, lane_oe}, 0);
      lb_n = 1; ub_n = 1;
      cyc(2);
      model[12 + i] = 16'hC0DE + 16'(i * 16'h0101);
    end
    idle();
    for (int i = 12; i < 16; i++) rd_chk(i, "R7 back-to-back words");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule